// File: doc/BRIEF.md
# Composite-Field GF(2^16) Multiplier

This block multiplies two 16-bit elements of GF(2^16). Internally each element is held as a pair of GF(2^8) coefficients (u1, u0), read as u1·β + u0, where β is a root of X^2 + X + c. Here c is a GF(2^8) constant set by a parameter, and the subfield is built over x^8 + x^4 + x^3 + x + 1. The product comes from five subfield multiplications, one of them by the constant c, followed by a reduction of the quadratic extension.

A mode input picks how the operands are read. In raw mode the operands and the product are composite pairs. In converted mode the operands are polynomial-basis elements of GF(2)[x]/(x^16+x^13+x^10+x^9+x^2+x+1). Each one passes through a forward change of basis, the product passes back through the inverse change, and the result is the ordinary polynomial-basis product. Each change of basis is a table of sixteen 16-bit vectors. Starting from zero, the vector for every set input bit is XORed in. Both tables are derived when the design is elaborated, from a root of the polynomial-basis modulus found inside the composite field.

The block has one register stage on its inputs and one on its output. A strobe entering with the operands comes out two cycles later, marking the product.

Top module: `gfc16_mult`

## Requirements
- R1: In raw mode (`in_cnv`=0), with bits [15:8] holding u1 and bits [7:0] holding u0, the high byte of `out_prod` is u1v0+u0v1+u1v1 and the low byte is u1v1·c+u0v0, where c = `EXT_C` (default 8'h20).
- R2: Subfield products reduce by x^8+x^4+x^3+x+1 (0x11B). In raw mode two operands whose high bytes are zero give a product whose high byte is zero and whose low byte is their GF(2^8) product.
- R3: In converted mode (`in_cnv`=1), `out_prod` is the product of `in_a` and `in_b` as polynomials over GF(2), reduced modulo x^16+x^13+x^10+x^9+x^2+x+1 (low bits 0x2607).
- R4: In both modes, multiplying by the unit element 16'h0001 returns the other operand unchanged. In converted mode this shows that the forward and inverse basis tables compose to the identity.
- R5: A zero operand in either position gives a zero product in both modes.
- R6: `out_vld` is high exactly two cycles after a cycle with `in_vld` high and low otherwise. One product leaves for every accepted pair, including operands accepted on consecutive cycles.
- R7: While no product is due, `out_prod` keeps its last value, and operands presented with `in_vld` low have no effect on it.
- R8: While `rst_n` is low, `out_vld` is 0 and `out_prod` is 16'h0000, whatever the inputs.
- R9: The mode is sampled together with each operand pair, so consecutive transactions may alternate between raw and converted mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand pair and mode are valid this cycle |
| in_cnv | input | 1 | 0: raw composite operands; 1: polynomial-basis operands with basis changes |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| out_vld | output | 1 | `out_prod` carries a new product this cycle |
| out_prod | output | 16 | Product, in the representation selected by the mode |

## Verification
Every product, and its strobe, is due two rising edges after the cycle in which its operands were presented. Nothing else in the block has its own timing. The bench drives on the falling edge and pushes each expected value into a two-deep expectation pipe. At the falling edge two steps later it compares the outputs with the entry leaving that pipe. On every cycle with no product due, it checks that the strobe is low and that the product still holds its last value.

// File: rtl/gfc16_pkg.sv
`timescale 1ns/1ps
package gfc16_pkg;
  localparam int SUB_W  = 8;
  localparam int FULL_W = 2 * SUB_W;
  localparam logic [SUB_W-1:0]  SUB_RED  = 8'h1B;     // x^8 + x^4 + x^3 + x + 1
  localparam logic [FULL_W-1:0] FULL_RED = 16'h2607;  // x^16+x^13+x^10+x^9+x^2+x+1

  typedef logic [FULL_W-1:0] elem_t;
  typedef logic [FULL_W-1:0][FULL_W-1:0] bmap_t;

  // GF(2^8) product, used only for elaboration-time constants
  function automatic logic [SUB_W-1:0] sub_mul(input logic [SUB_W-1:0] a,
                                               input logic [SUB_W-1:0] b);
    logic [SUB_W-1:0] acc;
    logic [SUB_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SUB_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SUB_W-1] ? ((sh << 1) ^ SUB_RED) : (sh << 1);
    end
    return acc;
  endfunction

  // Product in GF(2^8)[X]/(X^2 + X + c)
  function automatic elem_t ext_mul(input elem_t a, input elem_t b,
                                    input logic [SUB_W-1:0] c);
    logic [SUB_W-1:0] t2, t1, t0;
    t2 = sub_mul(a[FULL_W-1:SUB_W], b[FULL_W-1:SUB_W]);
    t1 = sub_mul(a[FULL_W-1:SUB_W], b[SUB_W-1:0]) ^ sub_mul(a[SUB_W-1:0], b[FULL_W-1:SUB_W]);
    t0 = sub_mul(a[SUB_W-1:0], b[SUB_W-1:0]);
    return {t1 ^ t2, sub_mul(t2, c) ^ t0};
  endfunction

  // True when r is a zero of the polynomial-basis modulus
  function automatic logic is_root(input elem_t r, input logic [SUB_W-1:0] c);
    elem_t r2, r4, r8, r9, r10, r12, r13, r16, sum;
    r2  = ext_mul(r, r, c);
    r4  = ext_mul(r2, r2, c);
    r8  = ext_mul(r4, r4, c);
    r9  = ext_mul(r8, r, c);
    r10 = ext_mul(r9, r, c);
    r12 = ext_mul(r10, r2, c);
    r13 = ext_mul(r12, r, c);
    r16 = ext_mul(r8, r8, c);
    sum = r16;
    if (FULL_RED[13]) sum = sum ^ r13;
    if (FULL_RED[10]) sum = sum ^ r10;
    if (FULL_RED[9])  sum = sum ^ r9;
    if (FULL_RED[2])  sum = sum ^ r2;
    if (FULL_RED[1])  sum = sum ^ r;
    if (FULL_RED[0])  sum = sum ^ elem_t'(1);
    return (sum == '0);
  endfunction

  // Composite image of the polynomial-basis generator x
  function automatic elem_t find_x_image(input logic [SUB_W-1:0] c);
    elem_t img;
    logic  found;
    img   = elem_t'(2);
    found = 1'b0;
    for (int hi = 1; hi < (1 << SUB_W) && !found; hi++) begin
      for (int lo = 0; lo < (1 << SUB_W) && !found; lo++) begin
        if (is_root({hi[SUB_W-1:0], lo[SUB_W-1:0]}, c)) begin
          img   = {hi[SUB_W-1:0], lo[SUB_W-1:0]};
          found = 1'b1;
        end
      end
    end
    return img;
  endfunction

  // Row i: composite image of x^i
  function automatic bmap_t build_fwd(input elem_t img, input logic [SUB_W-1:0] c);
    bmap_t tbl;
    tbl[0] = elem_t'(1);
    for (int i = 1; i < FULL_W; i++) tbl[i] = ext_mul(tbl[i-1], img, c);
    return tbl;
  endfunction

  // GF(2) inversion of a 16x16 basis map by elimination
  function automatic bmap_t invert_map(input bmap_t tbl);
    bmap_t im, pr;
    elem_t tmp;
    int    piv;
    for (int i = 0; i < FULL_W; i++) begin
      im[i] = tbl[i];
      pr[i] = elem_t'(1) << i;
    end
    for (int j = 0; j < FULL_W; j++) begin
      piv = -1;
      for (int k = j; k < FULL_W; k++) if (piv < 0 && im[k][j]) piv = k;
      if (piv >= 0) begin
        tmp = im[j]; im[j] = im[piv]; im[piv] = tmp;
        tmp = pr[j]; pr[j] = pr[piv]; pr[piv] = tmp;
        for (int k = 0; k < FULL_W; k++) begin
          if (k != j && im[k][j]) begin
            im[k] = im[k] ^ im[j];
            pr[k] = pr[k] ^ pr[j];
          end
        end
      end
    end
    return pr;
  endfunction
endpackage

// File: rtl/gfc16_sub_mul.sv
`timescale 1ns/1ps
// Combinational GF(2^W) multiplier: shift-and-add with per-step reduction
module gfc16_sub_mul #(
  parameter int            W   = 8,
  parameter logic [W-1:0]  RED = 8'h1B
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  for (genvar gi = 0; gi < W; gi++) begin : g_stage
    logic [W-1:0] sh;
    logic [W-1:0] acc;
    if (gi == 0) begin : g_first
      assign sh  = a;
      assign acc = b[0] ? a : '0;
    end else begin : g_next
      assign sh  = {g_stage[gi-1].sh[W-2:0], 1'b0} ^
                   (g_stage[gi-1].sh[W-1] ? RED : '0);
      assign acc = g_stage[gi-1].acc ^ (b[gi] ? sh : '0);
    end
  end
  assign p = g_stage[W-1].acc;
endmodule

// File: rtl/gfc16_ext_mul.sv
`timescale 1ns/1ps
// Product in GF(2^W)[X]/(X^2 + X + C): four cross products, one constant product
module gfc16_ext_mul #(
  parameter int           W   = 8,
  parameter logic [W-1:0] RED = 8'h1B,
  parameter logic [W-1:0] C   = 8'h20
) (
  input  logic [2*W-1:0] a,
  input  logic [2*W-1:0] b,
  output logic [2*W-1:0] p
);
  // xp[2*i+j] = a_i * b_j
  logic [W-1:0] xp [4];
  logic [W-1:0] hc;

  for (genvar gk = 0; gk < 4; gk++) begin : g_cross
    localparam int IA = gk / 2;
    localparam int IB = gk % 2;
    gfc16_sub_mul #(.W(W), .RED(RED)) i_mul (
      .a(a[IA*W +: W]),
      .b(b[IB*W +: W]),
      .p(xp[gk])
    );
  end

  gfc16_sub_mul #(.W(W), .RED(RED)) i_cmul (
    .a(xp[3]),
    .b(C),
    .p(hc)
  );

  assign p = {xp[2] ^ xp[1] ^ xp[3], hc ^ xp[0]};
endmodule

// File: rtl/gfc16_basis_map.sv
`timescale 1ns/1ps
// GF(2)-linear map: XOR of table rows selected by input bits
module gfc16_basis_map
  import gfc16_pkg::*;
#(
  parameter bmap_t TBL = '0
) (
  input  logic [FULL_W-1:0] din,
  output logic [FULL_W-1:0] dout
);
  for (genvar gi = 0; gi < FULL_W; gi++) begin : g_acc
    logic [FULL_W-1:0] part;
    if (gi == 0) begin : g_first
      assign part = din[0] ? TBL[0] : '0;
    end else begin : g_next
      assign part = g_acc[gi-1].part ^ (din[gi] ? TBL[gi] : '0);
    end
  end
  assign dout = g_acc[FULL_W-1].part;
endmodule

// File: rtl/gfc16_mult.sv
`timescale 1ns/1ps
module gfc16_mult
  import gfc16_pkg::*;
#(
  parameter logic [SUB_W-1:0] EXT_C = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_cnv,
  input  logic [FULL_W-1:0] in_a,
  input  logic [FULL_W-1:0] in_b,
  output logic              out_vld,
  output logic [FULL_W-1:0] out_prod
);
  // Basis tables derived at elaboration
  localparam elem_t X_IMG   = find_x_image(EXT_C);
  localparam bmap_t FWD_TBL = build_fwd(X_IMG, EXT_C);
  localparam bmap_t INV_TBL = invert_map(FWD_TBL);

  // input stage
  logic              s1_en;
  logic              s1_vld_d, s1_vld_q;
  logic              s1_cnv_d, s1_cnv_q;
  logic [FULL_W-1:0] s1_a_d, s1_a_q;
  logic [FULL_W-1:0] s1_b_d, s1_b_q;
  // datapath
  logic [FULL_W-1:0] map_a, map_b, ext_a, ext_b, ext_p, back_p, res;
  // output stage
  logic              o_en;
  logic              o_vld_d, o_vld_q;
  logic [FULL_W-1:0] o_prod_d, o_prod_q;

  always_comb begin
    s1_en    = in_vld;
    s1_vld_d = in_vld;
    s1_cnv_d = s1_en ? in_cnv : s1_cnv_q;
    s1_a_d   = s1_en ? in_a   : s1_a_q;
    s1_b_d   = s1_en ? in_b   : s1_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_cnv_q <= 1'b0;
      s1_a_q   <= '0;
      s1_b_q   <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_cnv_q <= s1_cnv_d;
      s1_a_q   <= s1_a_d;
      s1_b_q   <= s1_b_d;
    end
  end

  gfc16_basis_map #(.TBL(FWD_TBL)) i_fwd_a (.din(s1_a_q), .dout(map_a));
  gfc16_basis_map #(.TBL(FWD_TBL)) i_fwd_b (.din(s1_b_q), .dout(map_b));

  assign ext_a = s1_cnv_q ? map_a : s1_a_q;
  assign ext_b = s1_cnv_q ? map_b : s1_b_q;

  gfc16_ext_mul #(.W(SUB_W), .RED(SUB_RED), .C(EXT_C)) i_ext (
    .a(ext_a),
    .b(ext_b),
    .p(ext_p)
  );

  gfc16_basis_map #(.TBL(INV_TBL)) i_inv (.din(ext_p), .dout(back_p));

  assign res = s1_cnv_q ? back_p : ext_p;

  always_comb begin
    o_en     = s1_vld_q;
    o_vld_d  = s1_vld_q;
    o_prod_d = o_en ? res : o_prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld_q  <= 1'b0;
      o_prod_q <= '0;
    end else begin
      o_vld_q  <= o_vld_d;
      o_prod_q <= o_prod_d;
    end
  end

  assign out_vld  = o_vld_q;
  assign out_prod = o_prod_q;
endmodule

// File: rtl/gfc16_mult_chk.sv
`timescale 1ns/1ps
module gfc16_mult_chk
  import gfc16_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [FULL_W-1:0] in_a,
  input logic [FULL_W-1:0] in_b,
  input logic              out_vld,
  input logic [FULL_W-1:0] out_prod
);
  logic              p1_vld, p2_vld;
  logic              p1_zero, p2_zero;
  logic              p1_one, p2_one;
  logic [FULL_W-1:0] p1_a, p2_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_vld <= 1'b0; p2_vld <= 1'b0;
      p1_zero <= 1'b0; p2_zero <= 1'b0;
      p1_one <= 1'b0; p2_one <= 1'b0;
      p1_a <= '0; p2_a <= '0;
    end else begin
      p1_vld  <= in_vld;
      p1_zero <= in_vld && (in_a == '0 || in_b == '0);
      p1_one  <= in_vld && (in_b == FULL_W'(1));
      p1_a    <= in_a;
      p2_vld  <= p1_vld;
      p2_zero <= p1_zero;
      p2_one  <= p1_one;
      p2_a    <= p1_a;
    end
  end

  a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == p2_vld);

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !p1_vld |=> $stable(out_prod));

  a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && p2_zero) |-> (out_prod == '0));

  a_r4_unit_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && p2_one) |-> (out_prod == p2_a));
endmodule

bind gfc16_mult gfc16_mult_chk i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .in_vld(in_vld),
  .in_a(in_a),
  .in_b(in_b),
  .out_vld(out_vld),
  .out_prod(out_prod)
);

// File: tb/test_gfc16_mult.sv
`timescale 1ns/1ps
module test_gfc16_mult;
  localparam logic [7:0] CVAL = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, in_cnv;
  logic [15:0] in_a, in_b;
  logic        out_vld;
  logic [15:0] out_prod;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gfc16_mult i_gfc16_mult (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_cnv(in_cnv),
    .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_prod(out_prod)
  );

  function automatic logic [7:0] m8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, t;
    r = '0; t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ t;
      t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
    end
    return r;
  endfunction

  // quadratic-extension reference: expand, then fold X^2 = X + c
  function automatic logic [15:0] cref(input logic [15:0] a, input logic [15:0] b);
    logic [7:0] t2, t1, t0;
    t2 = m8(a[15:8], b[15:8]);
    t1 = m8(a[15:8], b[7:0]) ^ m8(a[7:0], b[15:8]);
    t0 = m8(a[7:0], b[7:0]);
    return {t1 ^ t2, t0 ^ m8(t2, CVAL)};
  endfunction

  function automatic logic [15:0] pmul(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r, t;
    r = '0; t = a;
    for (int i = 0; i < 16; i++) begin
      if (b[i]) r = r ^ t;
      t = t[15] ? ((t << 1) ^ 16'h2607) : (t << 1);
    end
    return r;
  endfunction

  function automatic string auto_tag(input logic [15:0] a, input logic [15:0] b, input logic m);
    if (a == 0 || b == 0) return "R5";
    if (b == 16'h0001) return "R4";
    if (m) return "R3";
    if (a[15:8] == 0 && b[15:8] == 0) return "R2";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // two-deep expectation pipe
  logic        e1_v, e2_v;
  logic [15:0] e1_p, e2_p, last_p;
  string       e1_tag, e2_tag;

  task automatic step(input logic v, input logic m, input logic [15:0] a,
                      input logic [15:0] b, input string tag);
    @(negedge clk);
    if (e2_v) begin
      chk("R6", {15'd0, out_vld}, 16'd1);
      chk(e2_tag, out_prod, e2_p);
      last_p = e2_p;
    end else begin
      chk("R6", {15'd0, out_vld}, 16'd0);
      chk("R7", out_prod, last_p);
    end
    e2_v = e1_v; e2_p = e1_p; e2_tag = e1_tag;
    in_vld = v; in_cnv = m; in_a = a; in_b = b;
    e1_v   = v;
    e1_p   = m ? pmul(a, b) : cref(a, b);
    e1_tag = (tag == "") ? auto_tag(a, b, m) : tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra, rb;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; in_vld = 1'b1; in_cnv = 1'b0; in_a = 16'h1234; in_b = 16'h5678;
    e1_v = 0; e2_v = 0; e1_p = 0; e2_p = 0; last_p = 0; e1_tag = ""; e2_tag = "";
    // R8: reset holds outputs at zero despite active inputs
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_a = 16'($urandom); in_b = 16'($urandom); in_cnv = 1'($urandom);
      chk("R8", {15'd0, out_vld}, 16'd0);
      chk("R8", out_prod, 16'd0);
    end
    @(negedge clk);
    in_vld = 1'b0;
    rst_n  = 1'b1;

    // directed corners
    step(1, 0, 16'h0053, 16'h00CA, "R2");   // subfield inverse pair
    step(1, 0, 16'h0002, 16'h0080, "R2");   // reduction by 0x11B
    step(1, 0, 16'h0100, 16'h0100, "R1");   // beta*beta = beta + c
    step(1, 0, 16'hFFFF, 16'hFFFF, "R1");
    step(1, 1, 16'h0002, 16'h8000, "R3");   // x * x^15 = x^16 mod p
    step(1, 1, 16'hFFFF, 16'hFFFF, "R3");
    step(1, 1, 16'hBEEF, 16'h0001, "R4");
    step(1, 0, 16'hBEEF, 16'h0001, "R4");
    step(1, 1, 16'h0000, 16'h7777, "R5");
    step(1, 0, 16'h7777, 16'h0000, "R5");
    step(0, 1, 16'hAAAA, 16'h5555, "");     // R7: ignored operands
    step(0, 0, 16'h1111, 16'h2222, "");
    step(0, 0, 16'h0000, 16'h0000, "");
    // R9: same operands, alternating mode back to back
    for (int k = 0; k < 8; k++) step(1, 1'(k), 16'h3C5A, 16'hA5C3, "R9");

    // R4: unit operand in converted mode, broad coverage of the tables
    for (int k = 0; k < 64; k++) step(1, 1, 16'h0001 << (k % 16) ^ 16'($urandom), 16'h0001, "R4");

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      ra = 16'($urandom); rb = 16'($urandom);
      if ($urandom % 32 == 0) rb = 16'h0001;
      if ($urandom % 32 == 0) ra = 16'h0000;
      if ($urandom % 16 == 0) begin ra[15:8] = 0; rb[15:8] = 0; end
      step(1'($urandom % 4 != 0), 1'($urandom), ra, rb, "");
    end

    // drain
    for (int k = 0; k < 4; k++) step(0, 0, 16'($urandom), 16'($urandom), "");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule